// File: doc/BRIEF.md
# Configurable Asynchronous Serial Channel

A single full-duplex asynchronous serial channel with a byte-wide register port. Software programs the frame shape at run time through one configuration register: 7 or 8 data bits, one or two stop bits, and one of four parity modes. The mode with a parity bit held at zero lets the channel talk to peers that expect a parity slot without a computed value. An external rate generator supplies `tick_i`, which pulses `OVS` times per bit period. The prescaler select and divider count registers are only held here and are driven out to that generator.

The transmitter has a one-byte holding buffer in front of a shift register. It pulses `tx_irq_o` when a frame has fully left the line. The receiver finds the start bit by oversampling and samples every later bit at its middle. It places each character in a receive buffer and records parity, framing and overrun errors in a clear-on-read status register. A routing bit in the configuration chooses where a character with an error is signalled: on the ordinary receive interrupt, or on a separate error interrupt.

Top module: `sio_channel`

## Requirements
- R1: Registers sit at byte offsets: 0 config, 2 receive buffer, 3 error status, 4 transmit buffer (write only, reads 0), 5 transmit status, 6 prescaler select, 7 divider count. Config, prescaler and divider read back what was written, and the last two also drive `psel_o` and `div_o`. After reset every register reads 0 and `txd_o` is 1.
- R2: Config bit fields: bit7 clock enable, bit6 transmit enable, bit5 receive enable, bits4:3 parity mode, bit2 8-bit data (0 means 7-bit), bit1 two stop bits, bit0 error routing. A transmitted frame is a low start bit, then the data LSB first, then an optional parity bit, then 1 or 2 high stop bits. Each bit lasts `OVS` ticks.
- R3: Parity mode encoding: 00 means no parity bit, 01 a parity bit of 0, 10 odd parity (total ones in data plus parity is odd), 11 even parity. In 7-bit mode the parity covers bits 6:0 only.
- R4: Transmit status bit1 is set while the holding buffer has a byte not yet moved to the shifter. Bit0 is set while the shifter sends. A write to the transmit buffer while bit1 is set is ignored.
- R5: `tx_irq_o` gives a one-cycle pulse when each frame's last stop bit has finished.
- R6: The receiver places each received character in the receive buffer, with bit7 read as 0 in 7-bit mode. It looks only at the parity, length and routing fields, and checks only the first stop bit.
- R7: Status bit2 (parity error) is set when odd or even parity mismatches. In the zero-parity mode the received parity bit is not checked.
- R8: Status bit1 (framing error) is set when the first stop bit is sampled low.
- R9: Status bit0 (overrun) is set when a character completes while the previous one was never read. The newer character replaces the old one, and reading the receive buffer marks it read.
- R10: Reading the error status register clears all three error bits.
- R11: A character with no error pulses `rx_irq_o`. A character with an error pulses `rx_irq_o` when the routing bit is 1, and `err_irq_o` (and not `rx_irq_o`) when it is 0. The two interrupts never pulse together.
- R12: With clock enable low, both shifters, the transmit buffer flag, the unread flag and all error bits are held clear. Transmit-buffer writes are ignored and the line stays high.
- R13: Transmit enable low stops only the transmit path. Receive enable low stops only the receive path: characters are neither stored nor signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling tick, OVS per bit |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| psel_o | output | 8 | Prescaler select to the rate generator |
| div_o | output | 8 | Divider count to the rate generator |
| tx_irq_o | output | 1 | Transmit-complete pulse |
| rx_irq_o | output | 1 | Receive pulse |
| err_irq_o | output | 1 | Receive-error pulse (routing bit 0) |

## Verification
A frame built from the wrong config field shows up on `txd_o` as a wrong bit in the very frame sent after the config write. A receive-side sampling or counting error appears in the receive buffer or status register once the first stop bit has been sampled, and the interrupt pattern follows one cycle later. Stale buffer or error flags are exposed by the transmit status and error status registers, read right after the event, or by a missing or extra interrupt pulse within one frame time.

// File: rtl/sio_channel_pkg.sv
package sio_channel_pkg;
  localparam logic [2:0] A_CFG   = 3'd0;
  localparam logic [2:0] A_RBUF  = 3'd2;
  localparam logic [2:0] A_ESTAT = 3'd3;
  localparam logic [2:0] A_TBUF  = 3'd4;
  localparam logic [2:0] A_TSTAT = 3'd5;
  localparam logic [2:0] A_PSEL  = 3'd6;
  localparam logic [2:0] A_DIV   = 3'd7;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic      clk_en;
    logic      tx_en;
    logic      rx_en;
    par_mode_e par;
    logic      len8;
    logic      stop2;
    logic      err_route;
  } cfg_t;

  function automatic logic par_calc(logic [7:0] d, logic len8, par_mode_e m);
    logic x;
    x = ^(len8 ? d : {1'b0, d[6:0]});
    case (m)
      PAR_ODD:  par_calc = ~x;
      PAR_EVEN: par_calc = x;
      default:  par_calc = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx
  import sio_channel_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  par_mode_e  par_i,
  input  logic       len8_i,
  input  logic       stop2_i,
  output logic       txd_o,
  output logic       buf_full_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int FW = 12;
  localparam logic [CW-1:0] BIT_END = CW'(OVS - 1);

  logic [7:0]    buf_q;
  logic          full_q, busy_q, done_q;
  logic [FW-1:0] sh_q, frame;
  logic [3:0]    nleft_q, nbits, dbits;
  logic [CW-1:0] cnt_q;

  always_comb begin
    dbits = len8_i ? 4'd8 : 4'd7;
    frame = '1;
    frame[0] = 1'b0;
    frame[7:1] = buf_q[6:0];
    if (len8_i) frame[8] = buf_q[7];
    if (par_i != PAR_NONE) frame[dbits + 4'd1] = par_calc(buf_q, len8_i, par_i);
    nbits = 4'd1 + dbits + ((par_i != PAR_NONE) ? 4'd1 : 4'd0) + (stop2_i ? 4'd2 : 4'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0; full_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      sh_q <= '1; nleft_q <= '0; cnt_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      sh_q <= '1; nleft_q <= '0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !full_q) begin
        buf_q  <= data_i;
        full_q <= 1'b1;
      end
      if (!busy_q && full_q) begin
        sh_q    <= frame;
        nleft_q <= nbits;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
        full_q  <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == BIT_END) begin
          cnt_q   <= '0;
          sh_q    <= {1'b1, sh_q[FW-1:1]};
          nleft_q <= nleft_q - 4'd1;
          if (nleft_q == 4'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign txd_o      = busy_q ? sh_q[0] : 1'b1;
  assign buf_full_o = full_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_buf_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && full_q && !busy_q) |=> !full_q);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_channel_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  par_mode_e  par_i,
  input  logic       len8_i,
  output logic [7:0] data_o,
  output logic       done_o,
  output logic       pe_o,
  output logic       fe_o
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] BIT_END  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_END = CW'((OVS / 2 > 0) ? OVS / 2 - 1 : 0);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_e;

  rx_state_e     st_q;
  logic [1:0]    sync_q;
  logic          rxs;
  logic [CW-1:0] cnt_q, lim;
  logic [2:0]    bit_q, last_bit;
  logic [7:0]    sh_q, word, data_q;
  logic          par_q, done_q, pe_q, fe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign rxs = sync_q[1];

  assign lim      = (st_q == S_START) ? HALF_END : BIT_END;
  assign last_bit = len8_i ? 3'd7 : 3'd6;
  assign word     = len8_i ? sh_q : {1'b0, sh_q[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; par_q <= 1'b0;
      data_q <= '0; done_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0;
    end else if (!en_i) begin
      st_q <= S_IDLE; cnt_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (tick_i && !rxs) begin
          st_q  <= S_START;
          cnt_q <= '0;
        end
      end else if (tick_i) begin
        if (cnt_q != lim) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          case (st_q)
            S_START: begin
              bit_q <= '0;
              st_q  <= rxs ? S_IDLE : S_DATA;
            end
            S_DATA: begin
              sh_q <= {rxs, sh_q[7:1]};
              if (bit_q == last_bit) st_q <= (par_i != PAR_NONE) ? S_PAR : S_STOP;
              else                   bit_q <= bit_q + 3'd1;
            end
            S_PAR: begin
              par_q <= rxs;
              st_q  <= S_STOP;
            end
            default: begin
              done_q <= 1'b1;
              data_q <= word;
              fe_q   <= !rxs;
              pe_q   <= (par_i == PAR_ODD || par_i == PAR_EVEN) &&
                        (par_q != par_calc(word, len8_i, par_i));
              st_q   <= S_IDLE;
            end
          endcase
        end
      end
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
  assign pe_o   = pe_q;
  assign fe_o   = fe_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_zero_par_unchecked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && par_i == PAR_ZERO && $stable(par_i)) |-> !pe_q);
endmodule

// File: rtl/sio_channel.sv
module sio_channel
  import sio_channel_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic [7:0] psel_o,
  output logic [7:0] div_o,
  output logic       tx_irq_o,
  output logic       rx_irq_o,
  output logic       err_irq_o
);
  cfg_t       cfg_q;
  logic [7:0] psel_q, div_q, rbuf_q;
  logic       unread_q, pe_q, fe_q, ove_q, rx_irq_q, err_irq_q;
  logic       tx_full, tx_busy, tx_done;
  logic [7:0] rx_data;
  logic       rx_done, rx_pe, rx_fe, ove_new, any_err;
  logic       rd_rbuf, rd_estat;

  assign rd_rbuf  = rd_i && addr_i == A_RBUF;
  assign rd_estat = rd_i && addr_i == A_ESTAT;

  sio_tx #(.OVS(OVS)) u_tx (
    .clk_i, .rst_ni,
    .en_i      (cfg_q.clk_en && cfg_q.tx_en),
    .tick_i,
    .load_i    (wr_i && addr_i == A_TBUF),
    .data_i    (wdata_i),
    .par_i     (cfg_q.par),
    .len8_i    (cfg_q.len8),
    .stop2_i   (cfg_q.stop2),
    .txd_o,
    .buf_full_o(tx_full),
    .busy_o    (tx_busy),
    .done_o    (tx_done)
  );

  sio_rx #(.OVS(OVS)) u_rx (
    .clk_i, .rst_ni,
    .en_i   (cfg_q.clk_en && cfg_q.rx_en),
    .tick_i,
    .rxd_i,
    .par_i  (cfg_q.par),
    .len8_i (cfg_q.len8),
    .data_o (rx_data),
    .done_o (rx_done),
    .pe_o   (rx_pe),
    .fe_o   (rx_fe)
  );

  assign ove_new = unread_q;
  assign any_err = rx_pe || rx_fe || ove_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; psel_q <= '0; div_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CFG:   cfg_q  <= cfg_t'(wdata_i);
        A_PSEL:  psel_q <= wdata_i;
        A_DIV:   div_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0; unread_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; ove_q <= 1'b0;
      rx_irq_q <= 1'b0; err_irq_q <= 1'b0;
    end else if (!cfg_q.clk_en) begin
      unread_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; ove_q <= 1'b0;
      rx_irq_q <= 1'b0; err_irq_q <= 1'b0;
    end else begin
      rx_irq_q  <= rx_done && (!any_err || cfg_q.err_route);
      err_irq_q <= rx_done && any_err && !cfg_q.err_route;
      if (rd_rbuf) unread_q <= 1'b0;
      if (rd_estat) begin
        pe_q <= 1'b0; fe_q <= 1'b0; ove_q <= 1'b0;
      end
      if (rx_done) begin
        rbuf_q   <= rx_data;
        unread_q <= 1'b1;
        if (rx_pe)   pe_q  <= 1'b1;
        if (rx_fe)   fe_q  <= 1'b1;
        if (ove_new) ove_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CFG:   rdata_o = cfg_q;
      A_RBUF:  rdata_o = rbuf_q;
      A_ESTAT: rdata_o = {5'b0, pe_q, fe_q, ove_q};
      A_TSTAT: rdata_o = {6'b0, tx_full, tx_busy};
      A_PSEL:  rdata_o = psel_q;
      A_DIV:   rdata_o = div_q;
      default: rdata_o = '0;
    endcase
  end

  assign psel_o    = psel_q;
  assign div_o     = div_q;
  assign tx_irq_o  = tx_done;
  assign rx_irq_o  = rx_irq_q;
  assign err_irq_o = err_irq_q;

  p_irq_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_irq_q && err_irq_q));
  p_flags_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.clk_en |=> (!pe_q && !fe_q && !ove_q && !unread_q));
  p_clear_on_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_estat && !rx_done) |=> (!pe_q && !fe_q && !ove_q));
endmodule

// File: tb/tb_sio_channel.sv
`timescale 1ns/1ps
module tb_sio_channel;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       rx_line = 1'b1, txd;
  logic [7:0] psel, div;
  logic       tx_irq, rx_irq, err_irq;

  int n_chk = 0, n_fail = 0;
  int c_tx = 0, c_rx = 0, c_err = 0, c_txlow = 0;

  always #2.5 clk = ~clk;

  sio_channel #(.OVS(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rxd_i(rx_line), .txd_o(txd), .psel_o(psel), .div_o(div),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  always @(negedge clk) begin
    if (tx_irq)  c_tx++;
    if (rx_irq)  c_rx++;
    if (err_irq) c_err++;
    if (!txd)    c_txlow++;
  end

  // {cfg, data}
  localparam logic [15:0] VEC [6] = '{
    16'hE4_55, 16'hE6_A3, 16'hF4_37, 16'hFC_81, 16'hE8_7F, 16'hFA_C5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic mk_frame(input logic [7:0] cfg, input logic [7:0] d,
                          output logic [11:0] f, output int n);
    int dl, ones;
    dl = cfg[2] ? 8 : 7;
    ones = 0;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin
      f[1+i] = d[i];
      ones += int'(d[i]);
    end
    n = 1 + dl;
    if (cfg[4:3] != 2'b00) begin
      case (cfg[4:3])
        2'b01:   f[n] = 1'b0;
        2'b10:   f[n] = (ones % 2 == 0);
        default: f[n] = (ones % 2 == 1);
      endcase
      n++;
    end
    n += cfg[1] ? 2 : 1;
  endtask

  task automatic drive(input logic [11:0] f, input int n, input int last_len);
    for (int i = 0; i < n; i++) begin
      rx_line = f[i];
      repeat ((i == n - 1) ? last_len : 16) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic capture(input int n, output logic [11:0] f);
    int w;
    f = '1;
    w = 0;
    while (txd !== 1'b0 && w < 2000) begin
      @(negedge clk); w++;
    end
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      f[i] = txd;
      if (i < n - 1) repeat (16) @(negedge clk);
    end
  endtask

  task automatic wait_tx_irq();
    int w;
    w = 0;
    while (tx_irq !== 1'b1 && w < 2000) begin
      @(negedge clk); w++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [11:0] ef, cf;
    int n, t0, r0, e0, l0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state and register map
    bus_rd(3'd0, r); chk("R1 cfg reset", r, 8'h00);
    bus_rd(3'd3, r); chk("R1 estat reset", r, 8'h00);
    bus_rd(3'd5, r); chk("R1 tstat reset", r, 8'h00);
    chk("R1 txd idle", txd, 1'b1);
    bus_wr(3'd6, 8'h03); bus_wr(3'd7, 8'h9B);
    bus_rd(3'd6, r); chk("R1 psel readback", r, 8'h03);
    bus_rd(3'd7, r); chk("R1 div readback", r, 8'h9B);
    chk("R1 ports", {psel, div}, 16'h039B);

    // table: R2 R3 R5 transmit, R6 receive
    for (int v = 0; v < 6; v++) begin
      logic [7:0] c, d, exp_d;
      c = VEC[v][15:8]; d = VEC[v][7:0];
      exp_d = c[2] ? d : {1'b0, d[6:0]};
      bus_wr(3'd0, c);
      bus_rd(3'd0, r); chk("R1 cfg readback", r, c);
      mk_frame(c, d, ef, n);
      t0 = c_tx;
      bus_wr(3'd4, d);
      capture(n, cf);
      chk("R2 R3 tx frame", cf, ef);
      repeat (20) @(negedge clk);
      chk("R5 tx irq count", c_tx - t0, 1);
      r0 = c_rx; e0 = c_err;
      drive(ef, n, 16);
      bus_rd(3'd2, r); chk("R6 rx data", r, exp_d);
      bus_rd(3'd3, r); chk("R6 rx status clean", r, 8'h00);
      chk("R6 rx irq", {c_rx - r0, c_err - e0}, {32'd1, 32'd0});
    end

    // R4 buffer flags and ignored write
    bus_wr(3'd0, 8'hE4);
    t0 = c_tx;
    bus_wr(3'd4, 8'h11);
    repeat (3) @(negedge clk);
    bus_wr(3'd4, 8'h22);
    bus_rd(3'd5, r); chk("R4 tstat full+busy", r, 8'h03);
    bus_wr(3'd4, 8'h33);
    wait_tx_irq();
    mk_frame(8'hE4, 8'h22, ef, n);
    capture(n, cf);
    chk("R4 second frame is buffered byte", cf, ef);
    repeat (200) @(negedge clk);
    chk("R4 R5 only two frames", c_tx - t0, 2);
    bus_rd(3'd5, r); chk("R4 tstat idle", r, 8'h00);

    // R7 R11 parity error routed to error irq
    bus_wr(3'd0, 8'hFC);
    mk_frame(8'hFC, 8'h81, ef, n); ef[9] = ~ef[9];
    r0 = c_rx; e0 = c_err;
    drive(ef, n, 16);
    bus_rd(3'd2, r);
    bus_rd(3'd3, r); chk("R7 parity error bit", r, 8'h04);
    chk("R11 route0 err irq only", {c_rx - r0, c_err - e0}, {32'd0, 32'd1});
    bus_wr(3'd0, 8'hFD);
    r0 = c_rx; e0 = c_err;
    drive(ef, n, 16);
    bus_rd(3'd2, r);
    bus_rd(3'd3, r); chk("R7 parity error bit route1", r, 8'h04);
    chk("R11 route1 rx irq", {c_rx - r0, c_err - e0}, {32'd1, 32'd0});

    // R7 zero-parity mode not checked
    bus_wr(3'd0, 8'hEC);
    mk_frame(8'hEC, 8'h5A, ef, n); ef[9] = 1'b1;
    r0 = c_rx;
    drive(ef, n, 16);
    bus_rd(3'd2, r); chk("R7 zero mode data", r, 8'h5A);
    bus_rd(3'd3, r); chk("R7 zero mode no check", r, 8'h00);
    chk("R7 zero mode rx irq", c_rx - r0, 1);

    // R8 framing error
    bus_wr(3'd0, 8'hE4);
    mk_frame(8'hE4, 8'h3C, ef, n); ef[9] = 1'b0;
    e0 = c_err;
    drive(ef, n, 12);
    bus_rd(3'd2, r);
    bus_rd(3'd3, r); chk("R8 framing error bit", r, 8'h02);
    chk("R8 err irq", c_err - e0, 1);

    // R9 overrun, R10 clear on read
    bus_wr(3'd0, 8'hE5);
    r0 = c_rx;
    mk_frame(8'hE5, 8'h12, ef, n); drive(ef, n, 16);
    mk_frame(8'hE5, 8'h34, ef, n); drive(ef, n, 16);
    bus_rd(3'd2, r); chk("R9 newest data kept", r, 8'h34);
    bus_rd(3'd3, r); chk("R9 overrun bit", r, 8'h01);
    chk("R9 irq count route1", c_rx - r0, 2);
    bus_rd(3'd3, r); chk("R10 status cleared", r, 8'h00);

    // R13 receive disabled, transmit disabled
    bus_wr(3'd0, 8'hC4);
    r0 = c_rx; e0 = c_err;
    mk_frame(8'hC4, 8'h99, ef, n); drive(ef, n, 16);
    bus_rd(3'd2, r); chk("R13 rbuf untouched", r, 8'h34);
    chk("R13 no rx irqs", {c_rx - r0, c_err - e0}, {32'd0, 32'd0});
    bus_wr(3'd0, 8'hA4);
    t0 = c_tx; l0 = c_txlow;
    bus_wr(3'd4, 8'h77);
    repeat (300) @(negedge clk);
    chk("R13 txd held high", c_txlow - l0, 0);
    bus_rd(3'd5, r); chk("R13 tstat idle", r, 8'h00);
    chk("R13 no tx irq", c_tx - t0, 0);

    // R12 clock enable low
    bus_wr(3'd0, 8'hE4);
    mk_frame(8'hE4, 8'h3C, ef, n); ef[9] = 1'b0;
    drive(ef, n, 12);
    bus_wr(3'd0, 8'h64);
    bus_rd(3'd3, r); chk("R12 flags cleared", r, 8'h00);
    t0 = c_tx; r0 = c_rx; e0 = c_err; l0 = c_txlow;
    bus_wr(3'd4, 8'h0F);
    drive(ef, n, 12);
    repeat (100) @(negedge clk);
    chk("R12 txd high", c_txlow - l0, 0);
    bus_rd(3'd5, r); chk("R12 tstat", r, 8'h00);
    bus_rd(3'd3, r); chk("R12 estat", r, 8'h00);
    chk("R12 no irqs", {c_tx - t0, c_rx - r0, c_err - e0}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule